// File: doc/BRIEF.md
# Transmit Dominant Timeout Guard

This block sits between the transmit-data line of a serial bus controller and the enable of the bus low-side driver. In normal operation a low transmit level pulls the bus dominant and a high level releases it to recessive. Two hazards are blocked: a transmit line stuck low holding the bus dominant indefinitely, and a transmit line that is already low when normal mode begins, which would otherwise make the bus go dominant the moment the driver is enabled.

Both hazards are handled by one arm/disarm rule. A continuous low period reaching the timeout length disarms the driver and raises a status flag. Once disarmed, the driver is re-armed only after the transmit input has stayed high for a qualifying number of ticks. The same qualifying high time is needed when normal mode is entered with the transmit input low. Durations are counted in ticks of an external timebase strobe. Under supply undervoltage and outside normal mode the driver is held off. The received bus level is passed straight through to the receive output.

Top module: `txd_dom_guard`

## Requirements
- R1: While the guard is armed, normal mode has been active for at least one clock edge and undervoltage is clear, `drv_dom` is 1 exactly when `txd_in` is 0 (1 = drive dominant). This response is combinational within the same cycle.
- R2: While `norm_mode` is 0, `drv_dom` is 0. Leaving normal mode clears `tmo_flag` at the next clock edge.
- R3: While `uv_flag` is 1, `drv_dom` is 0. Undervoltage does not pause or reset the timeout or re-arm timing, so the driver follows `txd_in` again as soon as `uv_flag` returns to 0.
- R4: When `txd_in` has been sampled 0 at TMO_TICKS consecutive tick edges in normal mode, then from that edge on `drv_dom` is 0 and `tmo_flag` is 1.
- R5: The low-time counter saturates at TMO_TICKS. Holding `txd_in` low for any number of further ticks keeps the driver off and the flag set, and re-arming still takes exactly REARM_TICKS high ticks.
- R6: After a timeout, the driver stays off until `txd_in` has been sampled 1 at REARM_TICKS consecutive tick edges. At that edge the guard re-arms and `tmo_flag` clears. A low sample in between restarts the high count.
- R7: If `txd_in` is 0 at the first clock edge with `norm_mode` 1, the guard starts disarmed and re-arms only after REARM_TICKS high ticks, without setting `tmo_flag`. If `txd_in` is 1 at that edge, the guard starts armed.
- R8: During the first cycle of normal mode, before that mode has been sampled at a clock edge, `drv_dom` is 0.
- R9: Reset leaves `drv_dom` 0, `tmo_flag` 0 and the guard waiting for a normal-mode entry.
- R10: `rxd_out` equals `bus_in` at all times.
- R11: Timing counters advance only at clock edges where `tick` is 1. With ticks spaced k cycles apart, a timeout takes k*TMO_TICKS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase strobe; counters advance on edges where it is 1 |
| txd_in | input | 1 | Transmit data level; 0 requests dominant |
| norm_mode | input | 1 | 1 while the transceiver is in normal mode |
| uv_flag | input | 1 | Supply undervoltage indication; 1 blocks the driver |
| bus_in | input | 1 | Received bus level |
| drv_dom | output | 1 | 1 commands the low-side driver to drive dominant |
| tmo_flag | output | 1 | 1 while the driver is disabled by a dominant timeout |
| rxd_out | output | 1 | Received bus level passed through |

## Verification
`drv_dom` and `rxd_out` depend combinationally on `txd_in`, `uv_flag`, `norm_mode` and `bus_in`. The bench therefore checks them one time unit after changing inputs on the falling clock edge, before the next rising edge can alter any state. `tmo_flag` and the arm state are registered. Their effect of the Nth qualifying tick is due right after the rising edge that samples that tick, so the bench drives each step on a falling edge and samples one time unit after the following rising edge. The sweeps compare the count of ticks applied so far against TMO_TICKS or REARM_TICKS, including the counts just below, at and above each limit, and with ticks spaced one, two and three cycles apart.

// File: rtl/txd_dom_guard.sv
module txd_dom_guard #(
  parameter int TMO_TICKS   = 40000,
  parameter int REARM_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic txd_in,
  input  logic norm_mode,
  input  logic uv_flag,
  input  logic bus_in,
  output logic drv_dom,
  output logic tmo_flag,
  output logic rxd_out
);
  localparam int LW = $clog2(TMO_TICKS + 1);
  localparam int HW = $clog2(REARM_TICKS + 1);
  localparam logic [LW-1:0] LO_MAX = LW'(TMO_TICKS);
  localparam logic [HW-1:0] HI_MAX = HW'(REARM_TICKS);

  logic          norm_q;
  logic          armed;
  logic [LW-1:0] lo_cnt;
  logic [HW-1:0] hi_cnt;

  wire lo_hit = tick && (lo_cnt == LO_MAX - LW'(1));
  wire hi_hit = tick && (hi_cnt == HI_MAX - HW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_q   <= 1'b0;
      armed    <= 1'b0;
      tmo_flag <= 1'b0;
      lo_cnt   <= '0;
      hi_cnt   <= '0;
    end else if (!norm_mode) begin
      norm_q   <= 1'b0;
      armed    <= 1'b0;
      tmo_flag <= 1'b0;
      lo_cnt   <= '0;
      hi_cnt   <= '0;
    end else if (!norm_q) begin
      norm_q   <= 1'b1;
      armed    <= txd_in;
      tmo_flag <= 1'b0;
      lo_cnt   <= '0;
      hi_cnt   <= '0;
    end else if (!txd_in) begin
      hi_cnt <= '0;
      if (tick && lo_cnt != LO_MAX) lo_cnt <= lo_cnt + LW'(1);
      if (lo_hit) begin
        armed    <= 1'b0;
        tmo_flag <= 1'b1;
      end
    end else begin
      lo_cnt <= '0;
      if (tick && hi_cnt != HI_MAX) hi_cnt <= hi_cnt + HW'(1);
      if (hi_hit) begin
        armed    <= 1'b1;
        tmo_flag <= 1'b0;
      end
    end
  end

  assign drv_dom = norm_mode && norm_q && armed && !uv_flag && !txd_in;
  assign rxd_out = bus_in;

  AST_TMO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag |-> !drv_dom); // R4
  AST_FIRE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(norm_mode) && $past(norm_q) && !$past(txd_in) && $past(tick)
     && $past(lo_cnt) == LO_MAX - LW'(1)) |-> tmo_flag); // R4
  AST_LO_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    lo_cnt <= LO_MAX); // R5
  AST_REARM_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(txd_in)); // R6
  AST_ENTRY_LOW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(norm_mode) && !$past(norm_q) && !$past(txd_in)) |-> !drv_dom); // R7
  AST_LEAVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(norm_mode) |-> !tmo_flag); // R2
endmodule

// File: tb/sim_txd_dom_guard.sv
module sim_txd_dom_guard;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 5;
  localparam int RA  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tk = 1'b0, txd = 1'b1, norm = 1'b0, uv = 1'b0, bus = 1'b1;
  logic drv, tmo, rxd;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  txd_dom_guard #(.TMO_TICKS(TMO), .REARM_TICKS(RA)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tk), .txd_in(txd), .norm_mode(norm),
    .uv_flag(uv), .bus_in(bus), .drv_dom(drv), .tmo_flag(tmo), .rxd_out(rxd));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string req, input string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, got, exp);
    end
  endtask

  task automatic step(input logic t, input logic k);
    @(negedge clk); txd = t; tk = k;
    @(posedge clk); #1;
  endtask

  task automatic peek(input logic t);
    @(negedge clk); txd = t; tk = 1'b0; #1;
  endtask

  task automatic enter(input logic t);
    @(negedge clk); norm = 1'b0; tk = 1'b0; uv = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); norm = 1'b1; txd = t;
    @(posedge clk); #1;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    #(CLK_PERIOD * 2);
    chk(drv, 1'b0, "R9", "drv in reset");
    chk(tmo, 1'b0, "R9", "tmo in reset");
    @(negedge clk); rst_n = 1'b1; txd = 1'b0;
    @(posedge clk); #1;
    chk(drv, 1'b0, "R9", "drv after reset");
    chk(tmo, 1'b0, "R9", "tmo after reset");

    for (int v = 0; v < 4; v++) begin
      bus = v[0]; #1;
      chk(rxd, v[0], "R10", "rxd pass-through");
    end

    enter(1'b1);
    for (int v = 0; v < 8; v++) begin
      peek(logic'(v % 3 == 0));
      chk(drv, logic'(v % 3 != 0), "R1", "drv follows txd");
    end

    for (int l = 1; l <= TMO + 2; l++) begin
      enter(1'b1);
      for (int i = 1; i <= l; i++) begin
        step(1'b0, 1'b1);
        chk(tmo, logic'(i >= TMO), "R4", "tmo after low ticks");
        chk(drv, logic'(i < TMO), "R4", "drv after low ticks");
      end
    end

    enter(1'b1);
    for (int i = 0; i < 3 * TMO; i++) begin
      step(1'b0, 1'b0);
      chk(drv, 1'b1, "R11", "no tick no timeout");
    end
    for (int k = 2; k <= 3; k++) begin
      enter(1'b1);
      for (int c = 1; c <= k * (TMO + 1); c++) begin
        step(1'b0, logic'(c % k == 0));
        chk(tmo, logic'((c / k) >= TMO), "R11", "sparse tick timeout");
      end
    end

    for (int h = 0; h <= RA + 1; h++) begin
      enter(1'b1);
      for (int i = 0; i < TMO; i++) step(1'b0, 1'b1);
      for (int j = 1; j <= h; j++) begin
        step(1'b1, 1'b1);
        chk(tmo, logic'(j < RA), "R6", "tmo during rearm");
      end
      peek(1'b0);
      chk(drv, logic'(h >= RA), "R6", "drv after high ticks");
    end
    enter(1'b1);
    for (int i = 0; i < TMO; i++) step(1'b0, 1'b1);
    for (int j = 1; j < RA; j++) step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    for (int j = 1; j < RA; j++) step(1'b1, 1'b1);
    chk(tmo, 1'b1, "R6", "interrupted high restarts");
    step(1'b1, 1'b1);
    chk(tmo, 1'b0, "R6", "rearm after restart");

    enter(1'b1);
    for (int i = 1; i <= 40; i++) begin
      step(1'b0, 1'b1);
      if (i >= TMO) begin
        chk(drv, 1'b0, "R5", "saturated drv");
        chk(tmo, 1'b1, "R5", "saturated tmo");
      end
    end
    for (int j = 1; j < RA; j++) step(1'b1, 1'b1);
    chk(tmo, 1'b1, "R5", "rearm not early after long low");
    step(1'b1, 1'b1);
    peek(1'b0);
    chk(drv, 1'b1, "R5", "rearm after long low");

    for (int h = 0; h <= RA + 1; h++) begin
      enter(1'b0);
      peek(1'b0);
      chk(drv, 1'b0, "R7", "entry low blocks");
      for (int j = 1; j <= h; j++) begin
        step(1'b1, 1'b1);
        chk(tmo, 1'b0, "R7", "entry low no flag");
      end
      peek(1'b0);
      chk(drv, logic'(h >= RA), "R7", "entry low rearm");
    end
    enter(1'b1);
    peek(1'b0);
    chk(drv, 1'b1, "R7", "entry high armed");

    @(negedge clk); norm = 1'b0;
    @(posedge clk); #1;
    @(negedge clk); norm = 1'b1; txd = 1'b0; #1;
    chk(drv, 1'b0, "R8", "first normal cycle");

    enter(1'b1);
    @(negedge clk); norm = 1'b0; txd = 1'b0; #1;
    chk(drv, 1'b0, "R2", "outside normal");
    enter(1'b1);
    for (int i = 0; i < TMO; i++) step(1'b0, 1'b1);
    chk(tmo, 1'b1, "R2", "tmo before leave");
    @(negedge clk); norm = 1'b0;
    @(posedge clk); #1;
    chk(tmo, 1'b0, "R2", "leave clears tmo");

    enter(1'b1);
    @(negedge clk); uv = 1'b1; txd = 1'b0; tk = 1'b0; #1;
    chk(drv, 1'b0, "R3", "uv blocks");
    uv = 1'b0; #1;
    chk(drv, 1'b1, "R3", "uv release");
    uv = 1'b1;
    for (int i = 1; i < TMO; i++) begin
      step(1'b0, 1'b1);
      chk(drv, 1'b0, "R3", "uv during low");
      chk(tmo, 1'b0, "R3", "uv tmo pending");
    end
    @(negedge clk); uv = 1'b0; tk = 1'b0; #1;
    chk(drv, 1'b1, "R3", "armed after uv");
    step(1'b0, 1'b1);
    chk(tmo, 1'b1, "R3", "uv did not pause timer");
    chk(drv, 1'b0, "R3", "timeout after uv");

    summary();
  end
endmodule